// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver

This block scans a row of common-cathode seven-segment digits, one at a time, from a bank of latched BCD values. It works with a scan tick from a prescaler, so the same logic serves any system clock. Each digit owns a fixed slot of ticks. The first ticks of every slot are kept dark so that one digit's pattern never bleeds into the next digit.

The driver blanks zeros on the left of the number, up to the digit that carries the decimal point. Digits at or below that position always show. An overflow flag lights the point of the most significant digit and turns zero suppression off, so the full count stays visible. A test control lights every segment and point. An off control darkens all segment and strobe lines and overrides test. The digit strobes are exported, so neighbouring logic can sample switch lines in step with the scan.

Top module: `disp_scan_driver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dig_strobe`, `seg_out` and `dp_out` are all zero.
- R2: Each cycle with `scan_tick` high advances a slot counter. A slot lasts SLOT_TICKS ticks. Digits are visited in the order D1, D2 … DN and then wrap to D1. `dig_strobe[k-1]` drives digit Dk, and at most one strobe is high at any time.
- R3: During the first GAP_TICKS ticks of every slot, all strobes, segments and the point are low.
- R4: `seg_out[0]` is segment a and `seg_out[6]` is segment g. BCD 0–9 give the usual font (hex gfedcba: 3F 06 5B 4F 66 6D 7D 07 7F 6F). Codes 10–15 light no segment.
- R5: A digit above the point position is blanked when that digit and every more significant digit are zero.
- R6: Digits at or below the point position always show, zeros included.
- R7: While `ovf_flag` is high, no digit is blanked as a leading zero.
- R8: `dp_out` is high while the digit selected by `dp_sel` is strobed. The value 0 selects D1.
- R9: While `ovf_flag` is high, `dp_out` is also high whenever the most significant digit is strobed.
- R10: With `test_en` high and `off_en` low, every strobed slot shows all seven segments and the point.
- R11: With `off_en` high, all outputs are low, whatever `test_en` says.
- R12: Outputs are registered. They show the scan position and the inputs present at the previous clock edge, and an input change does not reach the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle pulse that advances the scan |
| digit_bcd | input | 4*N_DIGITS | BCD values. Nibble k-1 holds digit Dk |
| dp_sel | input | $clog2(N_DIGITS) | Index of the digit that carries the point (0 = D1) |
| ovf_flag | input | 1 | Overflow indicator |
| test_en | input | 1 | Light every segment and point |
| off_en | input | 1 | Turn every driver off |
| seg_out | output | 7 | Segments a..g, active high |
| dp_out | output | 1 | Decimal-point segment, active high |
| dig_strobe | output | N_DIGITS | One-hot digit strobes, active high |

## Verification
Three functions can act on the most significant digit in the same slot: the overflow point, the selected point and zero suppression. With `dp_sel` at 7 and `ovf_flag` high, both point sources request D8 at once. With zeros in the upper nibbles and overflow set, the suppression rule and the overflow rule disagree about whether the digit shows. Directed cases set up these collisions, and random patterns biased toward zero nibbles and overflow repeat them. The bench model decides each cycle's expected strobe, segments and point from the requirements alone. Test and off are also applied together, and the outputs must then be dark.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_FULL = 7'h7F;
    localparam seg_t SEG_NONE = 7'h00;

    // bit 0 = a ... bit 6 = g
    function automatic seg_t bcd_to_seg(input logic [3:0] val);
        seg_t pat;
        case (val)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = SEG_NONE;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/disp_scan_timer.sv
module disp_scan_timer #(
    parameter int N_DIGITS   = 8,
    parameter int SLOT_TICKS = 125,
    parameter int GAP_TICKS  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    output logic [$clog2(N_DIGITS)-1:0] idx,
    output logic                        lit
);
    localparam int IDX_W = $clog2(N_DIGITS);
    localparam int CNT_W = $clog2(SLOT_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_GAP  = CNT_W'(GAP_TICKS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DIGITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } scan_st_t;

    scan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                st_d.idx = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + IDX_W'(1);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
    assign lit = (st_q.cnt >= CNT_GAP);

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != $past(st_q.idx)) |->
            ($past(tick) && (st_q.idx == (($past(st_q.idx) == IDX_LAST) ? '0 : $past(st_q.idx) + IDX_W'(1))))); // R2

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt)); // R2

endmodule

// File: rtl/disp_zero_blank.sv
module disp_zero_blank #(
    parameter int N_DIGITS = 8
) (
    input  logic [4*N_DIGITS-1:0]       digit_bcd,
    input  logic [$clog2(N_DIGITS)-1:0] dp_sel,
    input  logic                        ovf,
    output logic [N_DIGITS-1:0]         blank
);
    localparam int IDX_W = $clog2(N_DIGITS);

    // walk from the most significant digit downward; suppression
    // survives only while each digit is zero and above the point
    always_comb begin
        logic run;
        run   = !ovf;
        blank = '0;
        for (int i = N_DIGITS - 1; i >= 0; i--) begin
            run      = run && (digit_bcd[i*4 +: 4] == 4'd0) && (IDX_W'(i) > dp_sel);
            blank[i] = run;
        end
    end

endmodule

// File: rtl/disp_glyph_sel.sv
module disp_glyph_sel
    import disp_pkg::*;
#(
    parameter int N_DIGITS = 8
) (
    input  logic [4*N_DIGITS-1:0]       digit_bcd,
    input  logic [N_DIGITS-1:0]         blank,
    input  logic [$clog2(N_DIGITS)-1:0] idx,
    input  logic [$clog2(N_DIGITS)-1:0] dp_sel,
    input  logic                        ovf,
    output seg_t                        seg,
    output logic                        dp
);
    localparam int IDX_W = $clog2(N_DIGITS);

    seg_t                seg_arr [N_DIGITS];
    logic [N_DIGITS-1:0] dp_arr;

    for (genvar i = 0; i < N_DIGITS; i++) begin : g_dig
        assign seg_arr[i] = blank[i] ? SEG_NONE : bcd_to_seg(digit_bcd[i*4 +: 4]);
        if (i == N_DIGITS - 1) begin : g_msd
            assign dp_arr[i] = (dp_sel == IDX_W'(i)) || ovf;
        end else begin : g_low
            assign dp_arr[i] = (dp_sel == IDX_W'(i));
        end
    end

    assign seg = seg_arr[idx];
    assign dp  = dp_arr[idx];

endmodule

// File: rtl/disp_scan_driver.sv
module disp_scan_driver
    import disp_pkg::*;
#(
    parameter int N_DIGITS   = 8,
    parameter int SLOT_TICKS = 125,
    parameter int GAP_TICKS  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scan_tick,
    input  logic [4*N_DIGITS-1:0]       digit_bcd,
    input  logic [$clog2(N_DIGITS)-1:0] dp_sel,
    input  logic                        ovf_flag,
    input  logic                        test_en,
    input  logic                        off_en,
    output logic [6:0]                  seg_out,
    output logic                        dp_out,
    output logic [N_DIGITS-1:0]         dig_strobe
);
    localparam int IDX_W = $clog2(N_DIGITS);
    localparam logic [IDX_W-1:0] IDX_MSD = IDX_W'(N_DIGITS - 1);

    typedef struct packed {
        logic [N_DIGITS-1:0] strobe;
        seg_t                seg;
        logic                dp;
    } drive_t;

    logic [IDX_W-1:0]    scan_idx;
    logic                scan_lit;
    logic [N_DIGITS-1:0] blank;
    seg_t                glyph_seg;
    logic                glyph_dp;
    drive_t              drv_d, drv_q;

    disp_scan_timer #(
        .N_DIGITS  (N_DIGITS),
        .SLOT_TICKS(SLOT_TICKS),
        .GAP_TICKS (GAP_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (scan_tick),
        .idx  (scan_idx),
        .lit  (scan_lit)
    );

    disp_zero_blank #(
        .N_DIGITS(N_DIGITS)
    ) u_blank (
        .digit_bcd(digit_bcd),
        .dp_sel   (dp_sel),
        .ovf      (ovf_flag),
        .blank    (blank)
    );

    disp_glyph_sel #(
        .N_DIGITS(N_DIGITS)
    ) u_glyph (
        .digit_bcd(digit_bcd),
        .blank    (blank),
        .idx      (scan_idx),
        .dp_sel   (dp_sel),
        .ovf      (ovf_flag),
        .seg      (glyph_seg),
        .dp       (glyph_dp)
    );

    always_comb begin
        drv_d = '0;
        if (!off_en && scan_lit) begin
            drv_d.strobe[scan_idx] = 1'b1;
            if (test_en) begin
                drv_d.seg = SEG_FULL;
                drv_d.dp  = 1'b1;
            end else begin
                drv_d.seg = glyph_seg;
                drv_d.dp  = glyph_dp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign dig_strobe = drv_q.strobe;
    assign seg_out    = drv_q.seg;
    assign dp_out     = drv_q.dp;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_strobe)); // R2

    AST_DARK_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_strobe == '0) |-> ((seg_out == '0) && !dp_out)); // R3

    AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        off_en |=> ((dig_strobe == '0) && (seg_out == '0) && !dp_out)); // R11

    AST_TEST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !off_en && scan_lit) |=> ((seg_out == SEG_FULL) && dp_out)); // R10

    AST_OVF_NO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (blank == '0)); // R7

    AST_OVF_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !off_en && scan_lit && (scan_idx == IDX_MSD)) |=> dp_out); // R9

endmodule

// File: tb/sim_disp_scan_driver.sv
module sim_disp_scan_driver;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int SLOT = 6;
    localparam int GAP  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_tick = 1'b0;
    logic [4*N-1:0] digit_bcd = '0;
    logic [2:0]     dp_sel = '0;
    logic           ovf_flag = 1'b0;
    logic           test_en = 1'b0;
    logic           off_en = 1'b0;
    logic [6:0]     seg_out;
    logic           dp_out;
    logic [N-1:0]   dig_strobe;

    int  m_cnt = 0;
    int  m_idx = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_scan_driver #(.N_DIGITS(N), .SLOT_TICKS(SLOT), .GAP_TICKS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .digit_bcd(digit_bcd),
        .dp_sel(dp_sel), .ovf_flag(ovf_flag), .test_en(test_en), .off_en(off_en),
        .seg_out(seg_out), .dp_out(dp_out), .dig_strobe(dig_strobe)
    );

    function automatic logic [6:0] ref_font(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    function automatic logic [3:0] nib(input int k);
        return digit_bcd[k*4 +: 4];
    endfunction

    // {strobe[7:0], dp, seg[6:0]}
    function automatic logic [15:0] ref_out(input int cnt, input int idx);
        logic [7:0] stb;
        logic       p;
        logic [6:0] s;
        bit         lead;
        if (off_en || cnt < GAP) return 16'h0;
        stb = 8'(1 << idx);
        if (test_en) return {stb, 1'b1, 7'h7F};
        lead = 1'b0;
        if (!ovf_flag && idx > int'(dp_sel)) begin
            lead = 1'b1;
            for (int j = N - 1; j >= idx; j--)
                if (nib(j) != 4'd0) lead = 1'b0;
        end
        s = lead ? 7'h00 : ref_font(nib(idx));
        p = (idx == int'(dp_sel)) || (ovf_flag && idx == N - 1);
        return {stb, p, s};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit tk);
        logic [15:0] e;
        logic [15:0] a;
        string       tag;
        int          ci, cc;
        scan_tick = tk;
        @(posedge clk);
        cc = m_cnt; ci = m_idx;
        e  = ref_out(cc, ci);
        if (tk) begin
            if (m_cnt == SLOT - 1) begin
                m_cnt = 0;
                m_idx = (m_idx + 1) % N;
            end else m_cnt++;
        end
        @(negedge clk);
        a = {dig_strobe, dp_out, seg_out};
        if (off_en)                 tag = "R11 off";
        else if (cc < GAP)          tag = "R3 gap";
        else if (test_en)           tag = "R10 test";
        else if (a[15:8] !== e[15:8]) tag = "R2 strobe";
        else if (a[7] !== e[7])     tag = (ovf_flag && ci == N - 1) ? "R9 overflow point" : "R8 point";
        else if (ovf_flag)          tag = "R7 no blank on overflow";
        else if (ci <= int'(dp_sel)) tag = "R6 shown below point";
        else if (e[6:0] == 7'h00 && nib(ci) == 4'd0) tag = "R5 leading zero";
        else                        tag = "R4 font";
        chk(tag, a, e);
    endtask

    task automatic scan(input int cycles);
        for (int c = 0; c < cycles; c++) step(1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset", {dig_strobe, dp_out, seg_out}, 16'h0);
        rst_n = 1'b1;
        step(1'b0);
        chk("R1 first cycle", {dig_strobe, dp_out, seg_out}, 16'h0);

        // R5/R6: all zero, point at D3
        digit_bcd = 32'h0; dp_sel = 3'd2;
        scan(SLOT * N + 3);
        // R5: partial suppression
        digit_bcd = 32'h0012_0340; dp_sel = 3'd0;
        scan(SLOT * N);
        // R4: every code including 10..15
        digit_bcd = 32'h7654_3210; scan(SLOT * N);
        digit_bcd = 32'hFEDC_BA98; dp_sel = 3'd7; scan(SLOT * N);
        // R7/R9 with point also on D8
        digit_bcd = 32'h0000_0001; ovf_flag = 1'b1; scan(SLOT * N);
        dp_sel = 3'd3; scan(SLOT * N);
        ovf_flag = 1'b0;
        // R10 then R11 over R10
        test_en = 1'b1; scan(SLOT * N);
        off_en = 1'b1;  scan(SLOT * N);
        test_en = 1'b0; off_en = 1'b0;

        // R12: park in a lit slot, change an input, outputs hold until the edge
        while (m_cnt < GAP) step(1'b1);
        step(1'b0);
        begin
            logic [15:0] held;
            held = {dig_strobe, dp_out, seg_out};
            off_en = 1'b1;
            #1;
            chk("R12 no path before edge", {dig_strobe, dp_out, seg_out}, held);
            step(1'b0);
            chk("R12 dark after one edge", {dig_strobe, dp_out, seg_out}, 16'h0);
            off_en = 1'b0;
        end

        // random phase
        for (int blk = 0; blk < 120; blk++) begin
            for (int k = 0; k < N; k++)
                digit_bcd[k*4 +: 4] = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 16);
            dp_sel   = 3'($urandom % 8);
            ovf_flag = ($urandom % 4) == 0;
            test_en  = ($urandom % 8) == 0;
            off_en   = ($urandom % 8) == 0;
            for (int c = 0; c < 40; c++) step(($urandom % 3) != 0);
        end
        finish_run();
    end
endmodule